// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block selects one winner among fifteen maskable interrupt sources. Each source has a request line and a local enable. A global mask input blocks all of them. Without intervention the sources follow a fixed ranking. A 4-bit promotion field in a small configuration register can raise any one source above all the others. The remaining sources keep their fixed ranking among themselves.

The block outputs a pending flag, the index of the winning source, and the vector slot of that source. The vector slot depends only on which source wins. It does not depend on whether that source won by promotion. The configuration register also holds four mode flags. These are loaded at reset from a two-bit mode strap, which must be held stable while reset is asserted. One of these flags, the boot-ROM enable, can also be written, but only in special modes. The whole register accepts writes only while the global mask is set, which avoids races with an interrupt that is being taken.

Top module: `prio_irq_resolver`

## Requirements
- R1: With no promotion in force, the lowest eligible index wins. The index order is: 0 external request, 1 periodic tick, 2..4 input capture 1..3, 5..8 output compare 1..4, 9 capture 4/compare 5, 10 timer wrap, 11 pulse-count overflow, 12 pulse-input edge, 13 SPI transfer done, 14 asynchronous serial.
- R2: A promotion code of 0..14 (register bits [3:0]) makes the source with that index win whenever it is eligible. Otherwise the R1 order applies.
- R3: A source is eligible only when its request and its local enable are both 1 and `gmask_i` is 0. A promoted source obeys the same rule. `irq_pend_o` is 1 exactly when some source is eligible, and `win_src_o` always names an eligible source.
- R4: `win_vec_o` equals 14 minus `win_src_o` while a source is pending. Both `win_vec_o` and `win_src_o` are 0 when nothing is pending.
- R5: A write (`wr_en_i`=1) updates bits [3:0] to `wr_data_i[3:0]` at the next clock only when `gmask_i` is 1. A write while `gmask_i` is 0 changes nothing in the register.
- R6: Promotion code 15 names no source and leaves the R1 order in force.
- R7: After reset, bits [3:0] read 0101. Bits [7:4] depend on `mode_i`: 00 (single chip) gives 0000, 01 (expanded) gives 0011, 10 (bootstrap) gives 1101, 11 (special test) gives 0111. Bits [6:4] never change afterwards.
- R8: Bit 7 (boot-ROM enable) takes `wr_data_i[7]` on an accepted write only while bit 6 (special mode) is 1. Otherwise it keeps its value.
- R9: `cfg_q_o` reads back the register at all times, laid out as {boot, special, mode-A, read-visibility, promotion[3:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 2 | Operating mode strap, sampled while reset is asserted |
| req_i | input | 15 | Per-source request lines |
| en_i | input | 15 | Per-source local enables |
| gmask_i | input | 1 | Global mask; 1 blocks all sources and permits register writes |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| cfg_q_o | output | 8 | Register readback |
| irq_pend_o | output | 1 | An eligible source exists |
| win_src_o | output | 4 | Index of the winning source |
| win_vec_o | output | 4 | Vector slot of the winning source |

## Verification
The bench sweeps all sixteen promotion codes under random request and enable patterns. A resolver that decoded code 15 as a source, or that put promoted sources back in the wrong order, would name the wrong winner here. It also gives the promoted source a request without its enable. A design that let promotion bypass the local enable or the global mask would then raise pending or pick that source. Writes are attempted with the mask clear, and the boot bit is written in every mode. A register that ignored the mask interlock, or let the boot bit change outside special modes, would show a changed readback value. The vector output is checked against the winning index on every cycle, so a design that tied the vector to priority rank rather than source identity would be caught.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int MODEW = 2;
  localparam int FLAGW = 4;

  typedef enum logic [MODEW-1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic boot;
    logic spec;
    logic mode_a;
    logic rd_vis;
  } mode_flags_t;

  function automatic mode_flags_t flags_for_mode(input logic [MODEW-1:0] m);
    mode_flags_t f;
    case (op_mode_e'(m))
      MODE_SINGLE: f = '{boot: 1'b0, spec: 1'b0, mode_a: 1'b0, rd_vis: 1'b0};
      MODE_EXPAND: f = '{boot: 1'b0, spec: 1'b0, mode_a: 1'b1, rd_vis: 1'b1};
      MODE_BOOT:   f = '{boot: 1'b1, spec: 1'b1, mode_a: 1'b0, rd_vis: 1'b1};
      default:     f = '{boot: 1'b0, spec: 1'b1, mode_a: 1'b1, rd_vis: 1'b1};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/prio_rst_sync.sv
module prio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/prio_cfg_reg.sv
module prio_cfg_reg
  import prio_irq_pkg::*;
#(
  parameter int SELW = 4,
  parameter logic [SELW-1:0] SEL_RST = 4'b0101,
  localparam int REGW = FLAGW + SELW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODEW-1:0] mode_i,
  input  logic             gmask_i,
  input  logic             wr_en_i,
  input  logic [REGW-1:0]  wr_data_i,
  output logic [SELW-1:0]  sel_o,
  output logic [REGW-1:0]  reg_o
);
  logic [SELW-1:0] sel_q, sel_nxt;
  mode_flags_t     flg_q;
  logic            boot_nxt;
  logic            wr_ok;

  assign wr_ok = wr_en_i & gmask_i;

  always_comb begin
    sel_nxt  = sel_q;
    boot_nxt = flg_q.boot;
    if (wr_ok) begin
      sel_nxt = wr_data_i[SELW-1:0];
      if (flg_q.spec) boot_nxt = wr_data_i[REGW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
      flg_q <= flags_for_mode(mode_i);
    end else begin
      sel_q      <= sel_nxt;
      flg_q.boot <= boot_nxt;
    end
  end

  assign sel_o = sel_q;
  assign reg_o = {flg_q, sel_q};

  p_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !gmask_i) |=> $stable(reg_o));
  p_boot_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_q.spec |=> $stable(flg_q.boot));
  p_mode_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(reg_o[REGW-2:SELW]));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NSRC = 15,
  parameter int SELW = 4
) (
  input  logic [NSRC-1:0] elig_i,
  input  logic [SELW-1:0] sel_i,
  output logic            pend_o,
  output logic [NSRC-1:0] gnt_o,
  output logic [SELW-1:0] win_o
);
  logic [NSRC:0]   seen;
  logic [NSRC-1:0] dflt_gnt, sel_dec, promo_gnt;
  logic            promo_hit;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign dflt_gnt[g]  = elig_i[g] & ~seen[g];
    assign seen[g+1]    = seen[g] | elig_i[g];
    assign sel_dec[g]   = (sel_i == SELW'(g));
    assign promo_gnt[g] = elig_i[g] & sel_dec[g];
  end

  assign promo_hit = |promo_gnt;
  assign gnt_o     = promo_hit ? promo_gnt : dflt_gnt;
  assign pend_o    = seen[NSRC];

  always_comb begin
    win_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt_o[i]) win_o = win_o | SELW'(i);
    end
  end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 15,
  parameter int SELW = 4,
  localparam int REGW = FLAGW + SELW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODEW-1:0] mode_i,
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  en_i,
  input  logic             gmask_i,
  input  logic             wr_en_i,
  input  logic [REGW-1:0]  wr_data_i,
  output logic [REGW-1:0]  cfg_q_o,
  output logic             irq_pend_o,
  output logic [SELW-1:0]  win_src_o,
  output logic [SELW-1:0]  win_vec_o
);
  logic            rst_sync_n;
  logic [SELW-1:0] sel_w;
  logic [NSRC-1:0] elig, gnt;
  logic [SELW-1:0] win;
  logic            pend;

  prio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  prio_cfg_reg #(.SELW(SELW)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .mode_i(mode_i), .gmask_i(gmask_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .sel_o(sel_w), .reg_o(cfg_q_o)
  );

  assign elig = req_i & en_i & {NSRC{~gmask_i}};

  prio_pick #(.NSRC(NSRC), .SELW(SELW)) u_pick (
    .elig_i(elig), .sel_i(sel_w), .pend_o(pend), .gnt_o(gnt), .win_o(win)
  );

  assign irq_pend_o = pend;
  assign win_src_o  = win;
  assign win_vec_o  = pend ? SELW'(NSRC - 1) - win : '0;

  p_onehot_gnt_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(gnt) && (pend == (gnt != '0)));
  p_pend_masked_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gmask_i |-> !irq_pend_o);
  p_win_eligible_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_pend_o |-> (((req_i & en_i) >> win_src_o) & NSRC'(1)) != '0);
  p_promoted_wins_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_pend_o && (((elig >> sel_w) & NSRC'(1)) != '0)) |-> win_src_o == sel_w);
  p_vec_identity_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_pend_o |-> (32'(win_vec_o) + 32'(win_src_o) == NSRC - 1));
endmodule

// File: tb/prio_irq_resolver_bench.sv
module prio_irq_resolver_bench;
  localparam int NSRC = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [14:0] req_i, en_i;
  logic        gmask_i, wr_en_i;
  logic [7:0]  wr_data_i;
  logic [7:0]  cfg_q_o;
  logic        irq_pend_o;
  logic [3:0]  win_src_o, win_vec_o;

  int total = 0;
  int bad = 0;
  int m_sel;
  bit m_boot, m_spec, m_ma, m_rv;

  always #2 clk = ~clk;

  prio_irq_resolver u_prio_irq_resolver (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i), .en_i(en_i),
    .gmask_i(gmask_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cfg_q_o(cfg_q_o), .irq_pend_o(irq_pend_o), .win_src_o(win_src_o),
    .win_vec_o(win_vec_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ref_win(input logic [14:0] e, input int sel);
    if (sel < NSRC && e[sel]) return sel;
    for (int i = 0; i < NSRC; i++) if (e[i]) return i;
    return -1;
  endfunction

  function automatic int ref_reg();
    return {m_boot, m_spec, m_ma, m_rv, 4'(m_sel)};
  endfunction

  task automatic compare_all(input string tag);
    logic [14:0] e;
    int w;
    e = gmask_i ? 15'd0 : (req_i & en_i);
    w = ref_win(e, m_sel);
    chk(cfg_q_o == 8'(ref_reg()), {tag, " R9 readback"}, cfg_q_o, ref_reg());
    chk(irq_pend_o == (w >= 0), {tag, " R3 pending"}, irq_pend_o, w >= 0);
    chk(win_src_o == ((w >= 0) ? 4'(w) : 4'd0), {tag, " R1/R2 winner"}, win_src_o, w);
    chk(win_vec_o == ((w >= 0) ? 4'(14 - w) : 4'd0), {tag, " R4 vector"}, win_vec_o,
        (w >= 0) ? 14 - w : 0);
  endtask

  task automatic step(input logic [14:0] rq, input logic [14:0] en, input bit gm,
                      input bit we, input logic [7:0] wd, input string tag);
    @(negedge clk);
    req_i = rq; en_i = en; gmask_i = gm; wr_en_i = we; wr_data_i = wd;
    @(posedge clk);
    if (we && gm) begin
      if (m_spec) m_boot = wd[7];
      m_sel = int'(wd[3:0]);
    end
    #1 compare_all(tag);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; wr_en_i = 1'b0; gmask_i = 1'b1;
    req_i = '0; en_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_sel = 5;
    case (m)
      2'b00: {m_boot, m_spec, m_ma, m_rv} = 4'b0000;
      2'b01: {m_boot, m_spec, m_ma, m_rv} = 4'b0011;
      2'b10: {m_boot, m_spec, m_ma, m_rv} = 4'b1101;
      default: {m_boot, m_spec, m_ma, m_rv} = 4'b0111;
    endcase
    chk(cfg_q_o == 8'(ref_reg()), "R7 reset value", cfg_q_o, ref_reg());
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; req_i = '0; en_i = '0;
    gmask_i = 1'b1; wr_en_i = 1'b0; wr_data_i = '0;

    for (int m = 0; m < 4; m++) do_reset(2'(m));

    do_reset(2'b00);
    // R5: write while unmasked is dropped
    step('0, '0, 1'b0, 1'b1, 8'h83, "R5 unmasked write");
    step('0, '0, 1'b1, 1'b1, 8'h82, "R5/R8 masked write single-chip");
    // R3: promoted source with local enable low does not win
    step(15'h7FFF, 15'h7FFB, 1'b0, 1'b0, 8'h00, "R3 promoted disabled");
    step(15'h7FFF, 15'h7FFF, 1'b1, 1'b0, 8'h00, "R3 masked all");
    step('0, '0, 1'b1, 1'b1, 8'h0F, "R6 write code 15");
    step(15'h7FFF, 15'h7FFF, 1'b0, 1'b0, 8'h00, "R6 all eligible");
    step('0, '0, 1'b1, 1'b1, 8'h0E, "R2 write code 14");
    step(15'h7FFF, 15'h7FFF, 1'b0, 1'b0, 8'h00, "R2 lowest promoted");
    step(15'h0001, 15'h7FFF, 1'b0, 1'b0, 8'h00, "R1 only top source");

    // sweep every promotion code with random patterns
    for (int s = 0; s < 16; s++) begin
      step('0, '0, 1'b1, 1'b1, 8'(s), "R2 set code");
      for (int k = 0; k < 60; k++) begin
        logic [14:0] rq, en;
        rq = 15'($urandom);
        en = 15'($urandom) | 15'($urandom);
        if (k % 4 == 0) rq = rq & 15'($urandom);
        step(rq, en, ($urandom % 8) == 0, 1'b0, 8'h00, "R1/R2/R6 sweep");
      end
    end

    // random writes with random mask in each mode (R5, R8)
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      for (int k = 0; k < 80; k++)
        step(15'($urandom), 15'($urandom), 1'($urandom), 1'($urandom),
             8'($urandom), "R5/R8 random write");
    end

    do_reset(2'b10);
    step('0, '0, 1'b1, 1'b1, 8'h05, "R8 boot cleared in bootstrap");
    step('0, '0, 1'b0, 1'b1, 8'h85, "R8 boot write unmasked");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule